// File: doc/BRIEF.md
# Interrupt Gating with Timed Disable

This block sits between the peripheral interrupt request lines and the processor core. Each cycle it decides which pending request, if any, may be presented to the core. A request passes only if all of these hold: its source enable bit is set, its priority level is above the current CPU priority level, and it is not held off by the timed-disable countdown. Among the requests that pass, the one with the highest level wins. Trap requests bypass every gate and take precedence over any interrupt.

Software controls the gates in three ways. A write port loads the per-source enable bits, which take effect after a fixed pipeline delay. A CPU priority level register can be written and read back, so code can save it, raise it and later restore it. A timed-disable command loads a countdown that blocks levels 1 to 6 for a programmed number of instruction cycles. A direct write to the countdown can cut that window short, but only while a window is open.

The selection logic is combinational from the registered state and the live request inputs. Register writes become visible after the clock edge that samples them.

Top module: `irq_gate`

## Requirements
- R1: A request from source s can be granted only while the effective enable bit s is 1. Enable bit s is bit s of the enable write data.
- R2: After reset, all effective enable bits are 0, the CPU priority level reads 0 and the countdown reads 0, so no request is granted.
- R3: Any asserted trap line sets `trap_vld_o` whatever the enables, countdown or priority level. When several trap lines are asserted, `trap_idx_o` gives the lowest-numbered one. While a trap is shown, `grant_vld_o` is 0.
- R4: While the countdown is nonzero, requests at levels 1 to 6 are not granted.
- R5: A timed-disable command loads its 14-bit count at the next clock edge. A count of 0 ends the window at once, and 0x3FFF is the largest count. If a command and a direct write arrive in the same cycle, the command wins.
- R6: A direct write to the countdown takes effect only when the countdown is nonzero at that edge. Otherwise the countdown is left unchanged.
- R7: The countdown never blocks a level-7 request. A level-7 request is blocked only by a CPU priority level of 7.
- R8: A write to the enable bits changes the effective enables at the EN_DELAY-th clock edge after the write is presented. EN_DELAY is 1 or 2.
- R9: Each instruction-cycle strobe lowers a nonzero countdown by one. A zero countdown stays at zero.
- R10: A request is granted only when its level is strictly greater than the CPU priority level. A level-0 request is never granted.
- R11: Among the eligible requests, the highest level wins. A tie goes to the lowest source index. `grant_idx_o` and `grant_lvl_o` are 0 when `grant_vld_o` is 0.
- R12: A write to the CPU priority level loads the 3-bit value at the next edge, and `ipl_o` reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NSRC | Raw interrupt request per source |
| req_lvl_i | input | 3*NSRC | Priority level per source, source s at bits [3s+2:3s] |
| trap_i | input | NTRAP | Trap request lines, index 0 highest |
| icyc_i | input | 1 | Instruction-cycle strobe |
| tdis_cmd_i | input | 1 | Timed-disable command |
| tdis_cnt_i | input | CNT_W | Count carried by the command |
| cnt_wr_i | input | 1 | Direct write to the countdown |
| cnt_wdata_i | input | CNT_W | Direct-write data |
| en_wr_i | input | 1 | Enable bank write strobe |
| en_wdata_i | input | NSRC | Enable bank write data |
| ipl_wr_i | input | 1 | CPU priority level write strobe |
| ipl_wdata_i | input | 3 | CPU priority level write data |
| ipl_o | output | 3 | CPU priority level readback |
| cnt_o | output | CNT_W | Countdown readback |
| grant_vld_o | output | 1 | An interrupt is presented to the core |
| grant_idx_o | output | IDX_W | Index of the presented source |
| grant_lvl_o | output | 3 | Level of the presented source |
| trap_vld_o | output | 1 | A trap is presented |
| trap_idx_o | output | TIDX_W | Index of the presented trap |

## Verification
Faults in the countdown appear on `cnt_o` one edge after the stimulus. A wrong decrement, a missed hold at zero, or a direct write accepted while idle are therefore caught at the next readback. A stuck or early enable pipeline shifts the cycle in which `grant_vld_o` first rises after an enable write, so the bench checks the cycle between the write and the expected change. Errors in level comparison, tie-breaking or the level-7 exemption show up combinationally as a wrong grant index or level in the same cycle as the request pattern.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_TOP = 3'd7;

  // Eligibility of one source: enabled, nonzero level above the CPU level,
  // and not held by the countdown unless it sits at the top level.
  function automatic logic f_eligible(input logic req, input logic en,
                                      input logic [LVL_W-1:0] lvl,
                                      input logic [LVL_W-1:0] ipl,
                                      input logic cnt_busy);
    logic lvl_ok;
    logic cnt_ok;
    lvl_ok = (lvl != '0) && (lvl > ipl);
    cnt_ok = !cnt_busy || (lvl == LVL_TOP);
    return req && en && lvl_ok && cnt_ok;
  endfunction
endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
  parameter int NSRC     = 8,
  parameter int EN_DELAY = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] en_q
);
  localparam int NSTG = (EN_DELAY > 1) ? EN_DELAY - 1 : 1;

  logic            commit;
  logic [NSRC-1:0] commit_data;

  generate
    if (EN_DELAY <= 1) begin : g_direct
      assign commit      = wr_i;
      assign commit_data = wdata_i;
    end else begin : g_pipe
      logic [NSTG-1:0] stg_vld;
      logic [NSRC-1:0] stg_dat [NSTG];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_vld <= '0;
          for (int i = 0; i < NSTG; i++) stg_dat[i] <= '0;
        end else begin
          stg_vld[0] <= wr_i;
          stg_dat[0] <= wdata_i;
          for (int i = 1; i < NSTG; i++) begin
            stg_vld[i] <= stg_vld[i-1];
            stg_dat[i] <= stg_dat[i-1];
          end
        end
      end
      assign commit      = stg_vld[NSTG-1];
      assign commit_data = stg_dat[NSTG-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= '0;
    else if (commit) en_q <= commit_data;
  end

  // R8
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(en_q));
  // R8
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> en_q == $past(commit_data));
endmodule

// File: rtl/irq_countdown.sv
module irq_countdown #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_i,
  input  logic [CNT_W-1:0] cmd_cnt_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_q,
  output logic             busy_o
);
  logic ev_load;
  logic ev_wr_ok;
  logic ev_dec;

  function automatic logic [CNT_W-1:0] f_dec(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  assign busy_o   = (cnt_q != '0);
  assign ev_load  = cmd_i;
  assign ev_wr_ok = !cmd_i && wr_i && busy_o;
  assign ev_dec   = !cmd_i && !ev_wr_ok && tick_i && busy_o;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (ev_load)  cnt_q <= cmd_cnt_i;
    else if (ev_wr_ok) cnt_q <= wdata_i;
    else if (ev_dec)   cnt_q <= f_dec(cnt_q);
  end

  // R9
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dec |=> cnt_q == $past(cnt_q) - 1'b1);
  // R6
  cnt_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !cmd_i && cnt_q == '0) |=> cnt_q == '0);
  // R9
  cnt_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_i && cnt_q == '0) |=> cnt_q == '0);
  // R5
  cnt_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i |=> cnt_q == $past(cmd_cnt_i));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_gate_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = 3
) (
  input  logic [NSRC-1:0]       elig_i,
  input  logic [NSRC*LVL_W-1:0] lvl_i,
  output logic                  vld_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic [LVL_W-1:0]      lvl_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (elig_i[s] && (!vld_o || lvl_i[s*LVL_W +: LVL_W] > lvl_o)) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(s);
        lvl_o = lvl_i[s*LVL_W +: LVL_W];
      end
    end
  end

  // R11
  arb_pick_elig_chk: assert final (!vld_o || elig_i[idx_o]);
  // R11
  arb_idle_zero_chk: assert final (vld_o || (idx_o == '0 && lvl_o == '0));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int NSRC     = 8,
  parameter int NTRAP    = 4,
  parameter int CNT_W    = 14,
  parameter int EN_DELAY = 1,
  parameter int IDX_W    = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter int TIDX_W   = (NTRAP > 1) ? $clog2(NTRAP) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       req_i,
  input  logic [NSRC*LVL_W-1:0] req_lvl_i,
  input  logic [NTRAP-1:0]      trap_i,
  input  logic                  icyc_i,
  input  logic                  tdis_cmd_i,
  input  logic [CNT_W-1:0]      tdis_cnt_i,
  input  logic                  cnt_wr_i,
  input  logic [CNT_W-1:0]      cnt_wdata_i,
  input  logic                  en_wr_i,
  input  logic [NSRC-1:0]       en_wdata_i,
  input  logic                  ipl_wr_i,
  input  logic [LVL_W-1:0]      ipl_wdata_i,
  output logic [LVL_W-1:0]      ipl_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  grant_vld_o,
  output logic [IDX_W-1:0]      grant_idx_o,
  output logic [LVL_W-1:0]      grant_lvl_o,
  output logic                  trap_vld_o,
  output logic [TIDX_W-1:0]     trap_idx_o
);
  logic [NSRC-1:0]  en_q;
  logic [LVL_W-1:0] ipl_q;
  logic             cnt_busy;
  logic [NSRC-1:0]  elig;
  logic             arb_vld;
  logic [IDX_W-1:0] arb_idx;
  logic [LVL_W-1:0] arb_lvl;

  irq_en_bank #(.NSRC(NSRC), .EN_DELAY(EN_DELAY)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_i(en_wr_i), .wdata_i(en_wdata_i), .en_q(en_q));

  irq_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cmd_i(tdis_cmd_i), .cmd_cnt_i(tdis_cnt_i),
    .wr_i(cnt_wr_i), .wdata_i(cnt_wdata_i), .tick_i(icyc_i),
    .cnt_q(cnt_o), .busy_o(cnt_busy));

  always_ff @(posedge clk) begin
    if (!rst_n)        ipl_q <= '0;
    else if (ipl_wr_i) ipl_q <= ipl_wdata_i;
  end
  assign ipl_o = ipl_q;

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_elig
      assign elig[s] = f_eligible(req_i[s], en_q[s],
                                  req_lvl_i[s*LVL_W +: LVL_W], ipl_q, cnt_busy);
    end
  endgenerate

  irq_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .elig_i(elig), .lvl_i(req_lvl_i),
    .vld_o(arb_vld), .idx_o(arb_idx), .lvl_o(arb_lvl));

  always_comb begin
    trap_idx_o = '0;
    for (int t = NTRAP - 1; t >= 0; t--) begin
      if (trap_i[t]) trap_idx_o = TIDX_W'(t);
    end
  end
  assign trap_vld_o = |trap_i;

  assign grant_vld_o = arb_vld && !trap_vld_o;
  assign grant_idx_o = grant_vld_o ? arb_idx : '0;
  assign grant_lvl_o = grant_vld_o ? arb_lvl : '0;

  // R10
  grant_above_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o |-> (grant_lvl_o > ipl_o && grant_lvl_o != '0));
  // R4
  cnt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && cnt_o != '0) |-> grant_lvl_o == LVL_TOP);
  // R3
  trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i != '0) |-> (trap_vld_o && !grant_vld_o));
  // R1
  grant_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o |-> (en_q[grant_idx_o] && req_i[grant_idx_o]));
  // R12
  ipl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ipl_wr_i |=> ipl_o == $past(ipl_wdata_i));
endmodule

// File: tb/tb_irq_gate.sv
module tb_irq_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC  = 4;
  localparam int NTRAP = 2;
  localparam int CNT_W = 14;
  localparam int IDX_W = 2;
  localparam int TIDX_W = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] req_i = '0;
  logic [NSRC*3-1:0] req_lvl_i = '0;
  logic [NTRAP-1:0] trap_i = '0;
  logic icyc_i = 1'b0, tdis_cmd_i = 1'b0, cnt_wr_i = 1'b0, en_wr_i = 1'b0, ipl_wr_i = 1'b0;
  logic [CNT_W-1:0] tdis_cnt_i = '0, cnt_wdata_i = '0;
  logic [NSRC-1:0] en_wdata_i = '0;
  logic [2:0] ipl_wdata_i = '0;
  logic [2:0] ipl_o;
  logic [CNT_W-1:0] cnt_o;
  logic grant_vld_o, trap_vld_o;
  logic [IDX_W-1:0] grant_idx_o;
  logic [2:0] grant_lvl_o;
  logic [TIDX_W-1:0] trap_idx_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_gate #(.NSRC(NSRC), .NTRAP(NTRAP), .CNT_W(CNT_W), .EN_DELAY(2)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_lvl_i(req_lvl_i), .trap_i(trap_i),
    .icyc_i(icyc_i), .tdis_cmd_i(tdis_cmd_i), .tdis_cnt_i(tdis_cnt_i),
    .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i), .en_wr_i(en_wr_i),
    .en_wdata_i(en_wdata_i), .ipl_wr_i(ipl_wr_i), .ipl_wdata_i(ipl_wdata_i),
    .ipl_o(ipl_o), .cnt_o(cnt_o), .grant_vld_o(grant_vld_o), .grant_idx_o(grant_idx_o),
    .grant_lvl_o(grant_lvl_o), .trap_vld_o(trap_vld_o), .trap_idx_o(trap_idx_o));

  typedef struct {
    string tag;
    bit    is_reg;
    bit    vld;
    int    idx;
    int    lvl;
    bit    tv;
    int    tidx;
    int    ipl;
    int    cnt;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Monitor: pops expected items and compares them with the ports.
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (e.is_reg) begin
          if (int'(ipl_o) != e.ipl || int'(cnt_o) != e.cnt) begin
            errors++;
            $display("FAIL %s: ipl=%0d cnt=%0h, expected ipl=%0d cnt=%0h",
                     e.tag, ipl_o, cnt_o, e.ipl, e.cnt);
          end
        end else begin
          if (grant_vld_o != e.vld || trap_vld_o != e.tv ||
              (e.vld && (int'(grant_idx_o) != e.idx || int'(grant_lvl_o) != e.lvl)) ||
              (e.tv && int'(trap_idx_o) != e.tidx)) begin
            errors++;
            $display("FAIL %s: vld=%0b idx=%0d lvl=%0d trap=%0b tidx=%0d, expected vld=%0b idx=%0d lvl=%0d trap=%0b tidx=%0d",
                     e.tag, grant_vld_o, grant_idx_o, grant_lvl_o, trap_vld_o, trap_idx_o,
                     e.vld, e.idx, e.lvl, e.tv, e.tidx);
          end
        end
      end
    end
  end

  task automatic exp_out(string tag, bit vld, int idx, int lvl, bit tv, int tidx);
    exp_t e;
    e.tag = tag; e.is_reg = 0; e.vld = vld; e.idx = idx; e.lvl = lvl;
    e.tv = tv; e.tidx = tidx; e.ipl = 0; e.cnt = 0;
    #1;
    exp_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  task automatic exp_reg(string tag, int ipl, int cnt);
    exp_t e;
    e.tag = tag; e.is_reg = 1; e.vld = 0; e.idx = 0; e.lvl = 0;
    e.tv = 0; e.tidx = 0; e.ipl = ipl; e.cnt = cnt;
    #1;
    exp_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_src(int s, bit r, int lvl);
    req_i[s] = r;
    req_lvl_i[s*3 +: 3] = 3'(lvl);
  endtask

  task automatic wr_en(logic [NSRC-1:0] d);
    en_wr_i = 1'b1; en_wdata_i = d; tick(); en_wr_i = 1'b0;
  endtask

  task automatic wr_ipl(int v);
    ipl_wr_i = 1'b1; ipl_wdata_i = 3'(v); tick(); ipl_wr_i = 1'b0;
  endtask

  task automatic cmd(int v);
    tdis_cmd_i = 1'b1; tdis_cnt_i = CNT_W'(v); tick(); tdis_cmd_i = 1'b0;
  endtask

  task automatic wr_cnt(int v);
    cnt_wr_i = 1'b1; cnt_wdata_i = CNT_W'(v); tick(); cnt_wr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < NSRC; s++) set_src(s, 1, 5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: enables clear, registers zero
    exp_out("R2 no grant after reset", 0, 0, 0, 0, 0);
    exp_reg("R2 ipl/cnt after reset", 0, 0);

    set_src(0, 1, 3); set_src(1, 1, 5); set_src(2, 1, 5); set_src(3, 1, 2);
    wr_en(4'b1111);
    exp_out("R8 enable not yet active after one edge", 0, 0, 0, 0, 0);
    tick();
    exp_out("R11 tie at level 5 goes to source 1", 1, 1, 5, 0, 0);

    wr_en(4'b1101);
    exp_out("R8 old enables still in force", 1, 1, 5, 0, 0);
    tick();
    exp_out("R1 disabled source 1 skipped", 1, 2, 5, 0, 0);

    wr_ipl(5);
    exp_reg("R12 ipl readback 5", 5, 0);
    exp_out("R10 level equal to ipl blocked", 0, 0, 0, 0, 0);
    set_src(3, 1, 6);
    exp_out("R10 level 6 above ipl 5", 1, 3, 6, 0, 0);
    wr_ipl(6);
    exp_out("R10 level 6 at ipl 6 blocked", 0, 0, 0, 0, 0);
    wr_ipl(0);
    exp_reg("R12 ipl restored to 0", 0, 0);

    for (int s = 0; s < NSRC; s++) set_src(s, 1, 0);
    exp_out("R10 level 0 never granted", 0, 0, 0, 0, 0);

    set_src(0, 0, 7); set_src(1, 1, 5); set_src(2, 1, 5); set_src(3, 0, 2);
    exp_out("R1 baseline source 2", 1, 2, 5, 0, 0);
    cmd(3);
    exp_reg("R5 count loaded 3", 0, 3);
    exp_out("R4 level 5 masked by countdown", 0, 0, 0, 0, 0);
    icyc_i = 1'b1;
    tick(); exp_reg("R9 decrement to 2", 0, 2);
    tick(); exp_reg("R9 decrement to 1", 0, 1);
    exp_out("R4 still masked at 1", 0, 0, 0, 0, 0);
    tick(); exp_reg("R9 decrement to 0", 0, 0);
    exp_out("R4 window over, source 2 again", 1, 2, 5, 0, 0);
    tick(); exp_reg("R9 holds at zero", 0, 0);
    icyc_i = 1'b0;

    cmd(16'h3FFF);
    exp_reg("R5 maximum count", 0, 'h3FFF);
    cmd(0);
    exp_reg("R5 zero count ends window", 0, 0);

    wr_cnt(100);
    exp_reg("R6 write ignored when idle", 0, 0);
    cmd(10);
    wr_cnt(7);
    exp_reg("R6 write accepted when busy", 0, 7);
    wr_cnt(0);
    exp_reg("R6 write of zero accepted", 0, 0);

    cmd(20);
    tdis_cmd_i = 1'b1; tdis_cnt_i = 5; cnt_wr_i = 1'b1; cnt_wdata_i = 9;
    tick();
    tdis_cmd_i = 1'b0; cnt_wr_i = 1'b0;
    exp_reg("R5 command wins over direct write", 0, 5);

    set_src(0, 1, 7);
    exp_out("R7 level 7 passes countdown", 1, 0, 7, 0, 0);
    wr_ipl(7);
    exp_out("R7 ipl 7 blocks level 7", 0, 0, 0, 0, 0);

    trap_i = 2'b10;
    exp_out("R3 trap unmasked at ipl 7 and busy count", 0, 0, 0, 1, 1);
    trap_i = 2'b11;
    exp_out("R3 lowest trap index wins", 0, 0, 0, 1, 0);
    wr_ipl(0);
    exp_out("R3 trap suppresses grant", 0, 0, 0, 1, 0);
    trap_i = 2'b00;
    exp_out("R7 grant returns after trap", 1, 0, 7, 0, 0);

    tick();
    finish_run();
  end
endmodule